// File: doc/BRIEF.md
# Fixed-Point Exception Status Register

This block keeps the exception status word of an integer execution unit. The word holds three flag bits and a small length field. The first flag is a summary-overflow flag: once set, it stays set. The second is a per-instruction overflow flag. The third is the carry flag. The length field is a 7-bit count that tells the indexed string load and store word operations how many bytes to move. Bits are numbered from the most significant end. Summary overflow is bit 0, overflow is bit 1, carry is bit 2, bits 3 to 24 are reserved, and the count sits in bits 25 to 31. In a 32-bit vector indexed `[31:0]`, these positions are `[31]`, `[30]`, `[29]`, `[28:7]` and `[6:0]`.

Three sources change the word:

- A move-to write loads the whole word at once.
- A copy-to-condition-field request reports the three flags and clears them in the same cycle.
- Strobes from the arithmetic pipeline carry each instruction's outcome. The overflow-recording strobe rewrites overflow and can only raise summary overflow. The carry strobe rewrites carry alone.

The full word is always readable for move-from reads. The registered carry is driven out as the carry-in for extended add and subtract operations.

Top module: `fx_status_reg`

## Requirements
- R1: A synchronous active-high `rst` clears the whole word, so `rdData` reads 0 after the reset edge.
- R2: With `wrEn` high, the next `rdData` takes the flags from `wrData[31:29]` and the count from `wrData[6:0]`. Reserved bits `rdData[28:7]` always read 0 whatever was written.
- R3: An overflow-recording update (`ovUpd`) sets overflow (`rdData[30]`) to `ovResult`. It sets summary overflow (`rdData[31]`) to its old value OR `ovResult`, so it never clears summary overflow.
- R4: A carry update (`caUpd`) sets carry (`rdData[29]`) to `caResult` and leaves `rdData[31:30]` unchanged.
- R5: While `crCopyReq` is high, `crField` shows `{SO, OV, CA, 0}` in the same cycle, taken before the clear (`crField[3]` is SO). After that edge, `rdData[31:29]` is 0. When no request is present, `crField` is 0.
- R6: A move-to write wins over a copy request and over both arithmetic strobes in the same cycle.
- R7: A copy request wins over arithmetic strobes in the same cycle, so the flags end at 0.
- R8: `carryIn` always equals the registered carry bit, and `byteCount` always equals `rdData[6:0]`.
- R9: The count changes only on a move-to write. Arithmetic updates and copy requests leave it intact.
- R10: When `ovUpd` and `caUpd` fire together, both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Move-to write strobe |
| wrData | input | 32 | Move-to write value |
| crCopyReq | input | 1 | Copy flags to condition field and clear them |
| ovUpd | input | 1 | Overflow-recording instruction completes |
| ovResult | input | 1 | That instruction overflowed |
| caUpd | input | 1 | Carry-updating instruction completes |
| caResult | input | 1 | That instruction's carry out |
| crField | output | 4 | Flags copied for the condition field |
| rdData | output | 32 | Full word for move-from reads |
| carryIn | output | 1 | Registered carry for extended arithmetic |
| byteCount | output | 7 | String transfer byte count |

## Verification
The collisions that matter are a move-to write or a copy request arriving in the same cycle as arithmetic strobes. The bench raises several of these inputs on one clock edge. It then compares the word read after that edge against the value that the winning source alone would produce. A separate case drives both arithmetic strobes together and checks that neither one masks the other.

// File: rtl/fx_status_pkg.sv
package fx_status_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned COUNT_W = 7;
  localparam int unsigned FLAG_N  = 3;
  localparam int unsigned CR_W    = 4;

  // One-cycle strobes issued by the control module to the datapath.
  typedef struct packed {
    logic loadAll;   // move-to write
    logic clrFlags;  // copy to condition field, then clear
    logic updOv;     // overflow-recording update
    logic updCa;     // carry update
  } ctrl_t;

endpackage

// File: rtl/fx_status_ctrl.sv
module fx_status_ctrl
  import fx_status_pkg::*;
(
  input  logic  wrEn,
  input  logic  crCopyReq,
  input  logic  ovUpd,
  input  logic  caUpd,
  output ctrl_t strobes
);

  // Priority: write, then copy-and-clear, then arithmetic updates.
  logic wrWins;
  logic copyWins;

  always_comb begin
    wrWins   = wrEn;
    copyWins = crCopyReq && !wrWins;

    strobes.loadAll  = wrWins;
    strobes.clrFlags = copyWins;
    strobes.updOv    = ovUpd && !wrWins && !copyWins;
    strobes.updCa    = caUpd && !wrWins && !copyWins;
  end

endmodule

// File: rtl/fx_status_dp.sv
module fx_status_dp
  import fx_status_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W,
  parameter int unsigned BC_W  = COUNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            strobes,
  input  logic [FLAG_N-1:0] wrFlags,
  input  logic [BC_W-1:0]  wrCount,
  input  logic             ovResult,
  input  logic             caResult,
  input  logic             copyReq,
  output logic [CR_W-1:0]  crField,
  output logic [WIDTH-1:0] word,
  output logic             carryQ,
  output logic [BC_W-1:0]  countQ
);

  localparam int unsigned SO_POS = WIDTH - 1;
  localparam int unsigned OV_POS = WIDTH - 2;
  localparam int unsigned CA_POS = WIDTH - 3;

  logic soQ, ovQ, caQ;
  logic soD, ovD, caD;
  logic [BC_W-1:0] bcQ, bcD;

  always_comb begin
    soD = soQ;
    ovD = ovQ;
    caD = caQ;
    bcD = bcQ;
    if (strobes.loadAll) begin
      soD = wrFlags[2];
      ovD = wrFlags[1];
      caD = wrFlags[0];
      bcD = wrCount;
    end else if (strobes.clrFlags) begin
      soD = 1'b0;
      ovD = 1'b0;
      caD = 1'b0;
    end else begin
      if (strobes.updOv) begin
        ovD = ovResult;
        soD = soQ | ovResult;
      end
      if (strobes.updCa) begin
        caD = caResult;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soQ <= 1'b0;
      ovQ <= 1'b0;
      caQ <= 1'b0;
      bcQ <= '0;
    end else begin
      soQ <= soD;
      ovQ <= ovD;
      caQ <= caD;
      bcQ <= bcD;
    end
  end

  // Pack the word; every bit not listed below is a reserved zero.
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_pack
      if (b == SO_POS) begin : g_so
        assign word[b] = soQ;
      end else if (b == OV_POS) begin : g_ov
        assign word[b] = ovQ;
      end else if (b == CA_POS) begin : g_ca
        assign word[b] = caQ;
      end else if (b < BC_W) begin : g_bc
        assign word[b] = bcQ[b];
      end else begin : g_res
        assign word[b] = 1'b0;
      end
    end
  endgenerate

  assign crField = copyReq ? {soQ, ovQ, caQ, 1'b0} : '0;
  assign carryQ  = caQ;
  assign countQ  = bcQ;

endmodule

// File: rtl/fx_status_reg.sv
module fx_status_reg
  import fx_status_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W,
  parameter int unsigned BC_W  = COUNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             crCopyReq,
  input  logic             ovUpd,
  input  logic             ovResult,
  input  logic             caUpd,
  input  logic             caResult,
  output logic [CR_W-1:0]  crField,
  output logic [WIDTH-1:0] rdData,
  output logic             carryIn,
  output logic [BC_W-1:0]  byteCount
);

  ctrl_t strobes;
  logic  unusedReserved;

  assign unusedReserved = ^wrData[WIDTH-FLAG_N-1:BC_W];

  fx_status_ctrl u_ctrl (
    .wrEn      (wrEn),
    .crCopyReq (crCopyReq),
    .ovUpd     (ovUpd),
    .caUpd     (caUpd),
    .strobes   (strobes)
  );

  fx_status_dp #(.WIDTH(WIDTH), .BC_W(BC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wrFlags  (wrData[WIDTH-1:WIDTH-FLAG_N]),
    .wrCount  (wrData[BC_W-1:0]),
    .ovResult (ovResult),
    .caResult (caResult),
    .copyReq  (crCopyReq),
    .crField  (crField),
    .word     (rdData),
    .carryQ   (carryIn),
    .countQ   (byteCount)
  );

endmodule

// File: rtl/fx_status_chk.sv
module fx_status_chk
  import fx_status_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W,
  parameter int unsigned BC_W  = COUNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [WIDTH-1:0] wrData,
  input logic             crCopyReq,
  input logic             ovUpd,
  input logic             ovResult,
  input logic             caUpd,
  input logic             caResult,
  input logic [CR_W-1:0]  crField,
  input logic [WIDTH-1:0] rdData,
  input logic             carryIn,
  input logic [BC_W-1:0]  byteCount
);

  localparam int unsigned SO = WIDTH - 1;
  localparam int unsigned OV = WIDTH - 2;
  localparam int unsigned CA = WIDTH - 3;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> rdData == '0);

  // R2
  write_load_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (rdData[SO:CA] == $past(wrData[SO:CA])) &&
             (byteCount == $past(wrData[BC_W-1:0])));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdData[CA-1:BC_W] == '0);

  // R3
  so_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !crCopyReq && rdData[SO]) |=> rdData[SO]);

  // R3
  ov_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (ovUpd && !wrEn && !crCopyReq) |=> rdData[OV] == $past(ovResult));

  // R4
  ca_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (caUpd && !wrEn && !crCopyReq) |=> rdData[CA] == $past(caResult));

  // R4
  ca_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovUpd && !wrEn && !crCopyReq) |=> $stable(rdData[SO:OV]));

  // R5
  cr_value_chk: assert property (@(posedge clk) disable iff (rst)
    crCopyReq |-> crField == {rdData[SO:CA], 1'b0});

  // R5
  cr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !crCopyReq |-> crField == '0);

  // R7
  cr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (crCopyReq && !wrEn) |=> rdData[SO:CA] == '0);

  // R8
  carry_out_chk: assert property (@(posedge clk) disable iff (rst)
    carryIn == rdData[CA] && byteCount == rdData[BC_W-1:0]);

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(byteCount));

endmodule

bind fx_status_reg fx_status_chk #(.WIDTH(WIDTH), .BC_W(BC_W)) u_chk (.*);

// File: tb/fx_status_reg_bench.sv
module fx_status_reg_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn, crCopyReq, ovUpd, ovResult, caUpd, caResult;
  logic [31:0] wrData;
  logic [3:0]  crField;
  logic [31:0] rdData;
  logic        carryIn;
  logic [6:0]  byteCount;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;
  logic [3:0] crPre;

  always #(CLK_PERIOD/2) clk = ~clk;

  fx_status_reg u_fx_status_reg (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .crCopyReq(crCopyReq), .ovUpd(ovUpd), .ovResult(ovResult),
    .caUpd(caUpd), .caResult(caResult), .crField(crField),
    .rdData(rdData), .carryIn(carryIn), .byteCount(byteCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; wrEn = 0; wrData = '0; crCopyReq = 0;
    ovUpd = 0; ovResult = 0; caUpd = 0; caResult = 0;
  endtask

  // Drive one cycle at the falling edge; crPre holds crField before the edge.
  task automatic step(input logic w, input logic [31:0] wd, input logic cr,
                      input logic ou, input logic orr, input logic cu, input logic crr);
    @(negedge clk);
    wrEn = w; wrData = wd; crCopyReq = cr;
    ovUpd = ou; ovResult = orr; caUpd = cu; caResult = crr;
    #1 crPre = crField;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic t_reset();
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    check("R1 reset word", rdData, 32'h0);
  endtask

  task automatic t_write();
    step(1, 32'hE000_0055, 0, 0, 0, 0, 0);
    check("R2 write", rdData, 32'hE000_0055);
    check("R8 byteCount", {25'h0, byteCount}, 32'h55);
    check("R8 carryIn", {31'h0, carryIn}, 32'h1);
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    check("R2 reserved masked", rdData, 32'hE000_007F);
  endtask

  task automatic t_sticky();
    step(1, 32'h0, 0, 0, 0, 0, 0);
    step(0, '0, 0, 1, 1, 0, 0);
    check("R3 overflow sets SO,OV", rdData, 32'hC000_0000);
    step(0, '0, 0, 1, 0, 0, 0);
    check("R3 SO sticky, OV cleared", rdData, 32'h8000_0000);
  endtask

  task automatic t_carry();
    step(0, '0, 0, 0, 0, 1, 1);
    check("R4 carry set", rdData, 32'hA000_0000);
    check("R8 carryIn follows", {31'h0, carryIn}, 32'h1);
    step(0, '0, 0, 0, 0, 1, 0);
    check("R4 carry cleared, SO kept", rdData, 32'h8000_0000);
  endtask

  task automatic t_copy();
    step(1, 32'hE000_0012, 0, 0, 0, 0, 0);
    check("R5 idle crField", {28'h0, crField}, 32'h0);
    step(0, '0, 1, 0, 0, 0, 0);
    check("R5 crField before clear", {28'h0, crPre}, 32'hE);
    check("R5 flags cleared, R9 count kept", rdData, 32'h0000_0012);
  endtask

  task automatic t_collide();
    step(1, 32'h2000_0003, 1, 1, 1, 1, 0);
    check("R6 write wins", rdData, 32'h2000_0003);
    step(1, 32'h0000_0005, 0, 0, 0, 0, 0);
    step(0, '0, 1, 1, 1, 1, 1);
    check("R7 copy wins over arithmetic", rdData, 32'h0000_0005);
    check("R7 crField from clean flags", {28'h0, crPre}, 32'h0);
    step(0, '0, 0, 1, 1, 1, 1);
    check("R10 both strobes", rdData, 32'hE000_0005);
    check("R9 count held over arithmetic", {25'h0, byteCount}, 32'h05);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    check("R1 initial reset", rdData, 32'h0);
    t_reset();
    t_write();
    t_sticky();
    t_carry();
    t_copy();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule